// File: doc/BRIEF.md
# Atomic Read-Modify-Write Engine

This engine carries out a single atomic memory update for a packet-filter style processor core. The core issues one command. The command holds an access size, an 8-bit operation code, a base address with a signed 16-bit displacement, the source register value and the value of register zero. The engine then reads the addressed word over a single-port memory port and works out the new value. If the operation calls for a store, it writes that value back. A lock output stays high over the whole read-modify-write so that an outside arbiter keeps other masters away.

Simple operations (add, or, and, xor) may optionally return the previous memory contents to the source register. Exchange always returns the previous contents to the source register. Compare-and-exchange compares memory against register zero and stores the source value only on a match. In both the match and the mismatch case it hands the previous contents back for register zero. Illegal commands end at once with an error and never touch memory.

The control path is a five-state machine:
- `ST_IDLE` goes to `ST_READ` on a legal start, or to `ST_DONE` on an illegal one.
- `ST_READ` goes to `ST_CALC` on acknowledge.
- `ST_CALC` goes to `ST_WRITE`. When a compare-and-exchange does not match, it goes to `ST_DONE` instead.
- `ST_WRITE` goes to `ST_DONE` on acknowledge.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `amo_engine`

## Requirements
- R1: `acc_size` 2'b00 selects a 32-bit access and 2'b11 a 64-bit access. The values 2'b01 and 2'b10 are rejected: `done` and `err` are high in the cycle after the start cycle, and no memory request is made.
- R2: Legal `op_imm` codes are 0x00 add, 0x40 or, 0x50 and, 0xA0 xor, each with or without bit 0 (the fetch bit) set, plus 0xE1 exchange and 0xF1 compare-and-exchange. Every other code is rejected as in R1, including 0xE0 and 0xF0.
- R3: Both the read and the write use address `base_addr` plus the sign-extended `offset`. A request is held, with a stable address, until `mem_ack`.
- R4: For add, or, and and xor, the written value is the old memory value combined with the source value, wrapping at the access width.
- R5: `src_wr` pulses with `done` exactly when the fetch bit is set and the operation is not compare-and-exchange. `src_out` then carries the old memory value, zero-extended.
- R6: Exchange writes the source value to memory and returns the old value on `src_out`.
- R7: A compare-and-exchange whose old value equals `r0_val` writes the source value to memory. `r0_wr` pulses with `done`, and `r0_out` carries the old value.
- R8: A compare-and-exchange that does not match makes no write request. `r0_wr` still pulses with `r0_out` equal to the zero-extended old value.
- R9: 32-bit accesses use only the low 32 bits of the source, of `r0_val` and of `mem_rdata`, with `mem_wide` low. Values returned by these accesses are zero-extended.
- R10: `mem_lock` is high whenever `mem_req` is high. It falls only in the cycle where `done` is high for a non-error command.
- R11: `done` is a one-cycle pulse. `src_wr`, `r0_wr` and `err` are high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled in the idle state |
| acc_size | input | 2 | Access size code |
| op_imm | input | 8 | Operation code with fetch bit |
| base_addr | input | 32 | Base address |
| offset | input | 16 | Signed displacement |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Register zero value (compare operand) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write enable for the request |
| mem_wide | output | 1 | High for 64-bit access, low for 32-bit |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Request acknowledge |
| mem_lock | output | 1 | Bus lock for the whole update |
| done | output | 1 | Completion pulse |
| err | output | 1 | Command rejected (with done) |
| src_wr | output | 1 | Source register update strobe |
| src_out | output | 64 | New source register value |
| r0_wr | output | 1 | Register zero update strobe |
| r0_out | output | 64 | New register zero value |

## Verification
A rejected command raises `done` with `err` in the first cycle after the start cycle. The bench checks for that exact cycle. A legal command finishes one cycle after the write acknowledge, or one cycle after the compare state when a compare misses. The memory responder's latency is random, so the bench waits for `done`, bounded by a cycle limit, instead of counting a fixed number of cycles. All result ports, the memory image, and the read and write addresses captured by the responder are checked in the `done` cycle. The bench then checks that `done` has dropped one cycle later.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_XCHG,
        OP_CMPX
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_DONE
    } amo_state_e;

    localparam logic [1:0] SZ_WORD  = 2'b00;
    localparam logic [1:0] SZ_DWORD = 2'b11;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [7:0] imm,
    input  logic [1:0] size,
    output logic       legal,
    output logic       fetch,
    output logic       wide,
    output amo_op_e    op
);
    logic code_ok;

    always_comb begin
        code_ok = 1'b1;
        op      = OP_ADD;
        unique case (imm)
            8'h00, 8'h01: op = OP_ADD;
            8'h40, 8'h41: op = OP_OR;
            8'h50, 8'h51: op = OP_AND;
            8'hA0, 8'hA1: op = OP_XOR;
            8'hE1:        op = OP_XCHG;
            8'hF1:        op = OP_CMPX;
            default:      code_ok = 1'b0;
        endcase
    end

    // R1 / R2: size and code legality
    assign wide  = (size == SZ_DWORD);
    assign legal = code_ok && ((size == SZ_WORD) || (size == SZ_DWORD));
    assign fetch = imm[0];

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_op_e             op,
    input  logic                wide,
    input  logic [DATA_W-1:0]   old_val,
    input  logic [DATA_W-1:0]   src,
    input  logic [DATA_W-1:0]   cmp,
    output logic [DATA_W-1:0]   new_val,
    output logic                match
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] full;

    always_comb begin
        unique case (op)
            OP_ADD:  full = old_val + src;
            OP_OR:   full = old_val | src;
            OP_AND:  full = old_val & src;
            OP_XOR:  full = old_val ^ src;
            OP_XCHG: full = src;
            OP_CMPX: full = src;
            default: full = src;
        endcase
    end

    // R9: narrow accesses keep only the low half
    assign new_val = wide ? full : {{HALF_W{1'b0}}, full[HALF_W-1:0]};
    assign match   = wide ? (old_val == cmp)
                          : (old_val[HALF_W-1:0] == cmp[HALF_W-1:0]);

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
    import amo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal,
    input  logic ack,
    input  logic skip_write,
    output logic req,
    output logic we,
    output logic lock,
    output logic done,
    output logic take_cmd,
    output logic take_old
);
    amo_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = legal ? ST_READ : ST_DONE;
            ST_READ:  if (ack)   state_nx = ST_CALC;
            ST_CALC:  state_nx = skip_write ? ST_DONE : ST_WRITE;
            ST_WRITE: if (ack)   state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req      = 1'b0;
        we       = 1'b0;
        lock     = 1'b0;
        done     = 1'b0;
        take_cmd = 1'b0;
        take_old = 1'b0;
        unique case (state)
            ST_IDLE:  take_cmd = start;
            ST_READ:  begin req = 1'b1; lock = 1'b1; take_old = ack; end
            ST_CALC:  lock = 1'b1;
            ST_WRITE: begin req = 1'b1; we = 1'b1; lock = 1'b1; end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/amo_engine.sv
module amo_engine
    import amo_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        acc_size,
    input  logic [7:0]        op_imm,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] r0_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              mem_lock,
    output logic              done,
    output logic              err,
    output logic              src_wr,
    output logic [DATA_W-1:0] src_out,
    output logic              r0_wr,
    output logic [DATA_W-1:0] r0_out
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = ADDR_W - OFF_W;

    logic    dec_legal, dec_fetch, dec_wide;
    amo_op_e dec_op;

    amo_op_e           op_q;
    logic              wide_q, fetch_q, err_q;
    logic [DATA_W-1:0] src_q, r0_q, old_q, new_val;
    logic [ADDR_W-1:0] addr_q;
    logic              match, skip_write, take_cmd, take_old;

    amo_decode u_dec (
        .imm   (op_imm),
        .size  (acc_size),
        .legal (dec_legal),
        .fetch (dec_fetch),
        .wide  (dec_wide),
        .op    (dec_op)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (op_q),
        .wide    (wide_q),
        .old_val (old_q),
        .src     (src_q),
        .cmp     (r0_q),
        .new_val (new_val),
        .match   (match)
    );

    // R8: a missed compare skips the store
    assign skip_write = (op_q == OP_CMPX) && !match;

    amo_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .legal      (dec_legal),
        .ack        (mem_ack),
        .skip_write (skip_write),
        .req        (mem_req),
        .we         (mem_we),
        .lock       (mem_lock),
        .done       (done),
        .take_cmd   (take_cmd),
        .take_old   (take_old)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_ADD;
            wide_q  <= 1'b0;
            fetch_q <= 1'b0;
            err_q   <= 1'b0;
            src_q   <= '0;
            r0_q    <= '0;
            addr_q  <= '0;
            old_q   <= '0;
        end else begin
            if (take_cmd) begin
                op_q    <= dec_op;
                wide_q  <= dec_wide;
                fetch_q <= dec_fetch;
                err_q   <= !dec_legal;
                src_q   <= src_val;
                r0_q    <= r0_val;
                // R3: effective address with sign-extended displacement
                addr_q  <= base_addr + {{EXT_W{offset[OFF_W-1]}}, offset};
            end
            if (take_old) begin
                old_q <= wide_q ? mem_rdata
                                : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
            end
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wide  = wide_q;
    assign mem_wdata = new_val;

    assign err     = done && err_q;
    assign src_wr  = done && !err_q && fetch_q && (op_q != OP_CMPX);
    assign r0_wr   = done && !err_q && (op_q == OP_CMPX);
    assign src_out = old_q;
    assign r0_out  = old_q;

endmodule

// File: rtl/amo_engine_chk.sv
module amo_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              err,
    input logic              src_wr,
    input logic              r0_wr
);
    assert_req_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    assert_lock_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> (done && !err));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_we_in_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_err_no_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !mem_req && !mem_lock));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_strobe_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr || r0_wr) |-> done);

    assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_wr && r0_wr));

endmodule

bind amo_engine amo_engine_chk #(.ADDR_W(ADDR_W)) u_amo_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_lock (mem_lock),
    .mem_addr (mem_addr),
    .done     (done),
    .err      (err),
    .src_wr   (src_wr),
    .r0_wr    (r0_wr)
);

// File: tb/test_amo_engine.sv
`timescale 1ns/1ps
module test_amo_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [7:0]  op_imm = '0;
    logic [31:0] base_addr = '0;
    logic [15:0] offset = '0;
    logic [63:0] src_val = '0;
    logic [63:0] r0_val = '0;
    logic        mem_req, mem_we, mem_wide, mem_lock;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        done, err, src_wr, r0_wr;
    logic [63:0] src_out, r0_out;

    always #2.5 clk = ~clk;

    amo_engine i_amo_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_size(acc_size),
        .op_imm(op_imm), .base_addr(base_addr), .offset(offset),
        .src_val(src_val), .r0_val(r0_val), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_lock(mem_lock), .done(done), .err(err), .src_wr(src_wr),
        .src_out(src_out), .r0_wr(r0_wr), .r0_out(r0_out)
    );

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          finished = 1'b0;

    // memory responder
    logic [63:0] mem [16];
    int          lat = 0;
    int          wait_cnt = 0;
    int          rd_cnt = 0, wr_cnt = 0, lock_bad = 0;
    logic [31:0] rd_addr = '0, wr_addr = '0;
    bit          wide_bad = 1'b0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            if (wait_cnt < lat) begin
                wait_cnt = wait_cnt + 1;
            end else begin
                wait_cnt = 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    wr_cnt  = wr_cnt + 1;
                    wr_addr = mem_addr;
                    if (mem_wide) mem[mem_addr[3:0]] = mem_wdata;
                    else          mem[mem_addr[3:0]][31:0] = mem_wdata[31:0];
                end else begin
                    rd_cnt  = rd_cnt + 1;
                    rd_addr = mem_addr;
                    // upper half is poisoned for narrow reads (R9)
                    mem_rdata <= mem_wide ? mem[mem_addr[3:0]]
                                          : {32'hDEAD_BEEF, mem[mem_addr[3:0]][31:0]};
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_req && !mem_lock) lock_bad = lock_bad + 1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit f_legal(input logic [1:0] sz, input logic [7:0] imm);
        bit code;
        code = (imm == 8'h00) || (imm == 8'h01) || (imm == 8'h40) || (imm == 8'h41) ||
               (imm == 8'h50) || (imm == 8'h51) || (imm == 8'hA0) || (imm == 8'hA1) ||
               (imm == 8'hE1) || (imm == 8'hF1);
        return code && ((sz == 2'b00) || (sz == 2'b11));
    endfunction

    function automatic logic [63:0] f_apply(input logic [7:0] imm, input logic [63:0] o,
                                            input logic [63:0] s);
        case (imm & 8'hFE)
            8'h00:   return o + s;
            8'h40:   return o | s;
            8'h50:   return o & s;
            8'hA0:   return o ^ s;
            default: return s;
        endcase
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic [7:0] imm,
                          input logic [31:0] base, input logic [15:0] off,
                          input logic [63:0] src, input logic [63:0] r0);
        logic [31:0] addr;
        logic [3:0]  idx;
        logic [63:0] old, nv, expmem;
        bit legal, wide, iscx, isx, hit, expwr;
        int n;
        string tag;
        legal = f_legal(sz, imm);
        wide  = (sz == 2'b11);
        addr  = base + {{16{off[15]}}, off};
        idx   = addr[3:0];
        old   = wide ? mem[idx] : {32'h0, mem[idx][31:0]};
        iscx  = (imm == 8'hF1);
        isx   = (imm == 8'hE1);
        hit   = wide ? (old == r0) : (old[31:0] == r0[31:0]);
        nv    = f_apply(imm, old, src);
        expwr = legal && !(iscx && !hit);
        expmem = mem[idx];
        if (expwr) begin
            if (wide) expmem = nv;
            else      expmem[31:0] = nv[31:0];
        end
        tag = iscx ? (hit ? "R7" : "R8") : (isx ? "R6" : (wide ? "R4" : "R9"));
        rd_cnt = 0; wr_cnt = 0; lock_bad = 0;
        @(negedge clk);
        acc_size = sz; op_imm = imm; base_addr = base; offset = off;
        src_val = src; r0_val = r0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(done, "R11 done seen", 64'(done), 64'd1);
        check(err == !legal, ((sz == 2'b01) || (sz == 2'b10)) ? "R1 err" : "R2 err",
              64'(err), 64'(!legal));
        if (!legal) begin
            check(n == 1, "R1 error latency", 64'(n), 64'd1);
            check(rd_cnt == 0 && wr_cnt == 0, "R2 no access", 64'(rd_cnt + wr_cnt), 64'd0);
            check(!src_wr && !r0_wr, "R11 no writeback on error", 64'({src_wr, r0_wr}), 64'd0);
        end else begin
            check(rd_cnt == 1, "R3 one read", 64'(rd_cnt), 64'd1);
            check(rd_addr == addr, "R3 read address", 64'(rd_addr), 64'(addr));
            check(wr_cnt == int'(expwr), iscx ? "R8 write count" : "R4 write count",
                  64'(wr_cnt), 64'(expwr));
            if (expwr) check(wr_addr == addr, "R3 write address", 64'(wr_addr), 64'(addr));
            check(mem[idx] == expmem, tag, mem[idx], expmem);
            check(src_wr == (imm[0] && !iscx), "R5 src_wr", 64'(src_wr), 64'(imm[0] && !iscx));
            if (src_wr) check(src_out == old, isx ? "R6 src_out" : "R5 src_out", src_out, old);
            check(r0_wr == iscx, "R7 r0_wr", 64'(r0_wr), 64'(iscx));
            if (r0_wr) check(r0_out == old, "R8 r0_out", r0_out, old);
            check(lock_bad == 0, "R10 lock", 64'(lock_bad), 64'd0);
        end
        @(negedge clk);
        check(!done, "R11 single pulse", 64'(done), 64'd0);
    endtask

    initial begin
        logic [7:0] codes [10];
        codes = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'hA0, 8'hA1, 8'hE1, 8'hF1};
        for (int i = 0; i < 16; i++) mem[i] = {32'h1111_0000 + i, 32'hA5A5_0000 + i};
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(!done && !mem_req && !mem_lock, "R11 reset state",
              64'({done, mem_req, mem_lock}), 64'd0);
        rst_n = 1'b1;

        // directed corner cases
        run_op(2'b01, 8'h00, 32'h10, 16'h0, 64'h1, 64'h0);           // R1 half
        run_op(2'b10, 8'h01, 32'h10, 16'h0, 64'h1, 64'h0);           // R1 byte
        run_op(2'b11, 8'hE0, 32'h10, 16'h0, 64'h1, 64'h0);           // R2 xchg no fetch
        run_op(2'b11, 8'hF0, 32'h10, 16'h0, 64'h1, 64'h0);           // R2 cmpx no fetch
        run_op(2'b00, 8'h02, 32'h10, 16'h0, 64'h1, 64'h0);           // R2 odd code
        mem[3] = 64'h7777_7777_FFFF_FFFF;
        run_op(2'b00, 8'h01, 32'h13, 16'h0, 64'hFFFF_0000_0000_0001, 64'h0); // R9 wrap
        lat = 2;
        run_op(2'b11, 8'h00, 32'h105, 16'hFFFE, 64'h1, 64'h0);       // R3 negative offset
        run_op(2'b11, 8'hE1, 32'h4, 16'h0, 64'hCAFE, 64'h0);         // R6
        run_op(2'b11, 8'hF1, 32'h5, 16'h0, 64'h55, mem[5]);          // R7 hit
        run_op(2'b11, 8'hF1, 32'h6, 16'h0, 64'h55, ~mem[6]);         // R8 miss
        run_op(2'b00, 8'hF1, 32'h7, 16'h0, 64'h99,
               {32'hFFFF_FFFF, mem[7][31:0]});                       // R9 narrow compare hit
        run_op(2'b11, 8'h50, 32'h8, 16'h0, 64'h0F0F, 64'h0);         // R5 no fetch

        // constrained random
        for (int k = 0; k < 300; k++) begin
            logic [1:0]  sz;
            logic [7:0]  imm;
            logic [31:0] b;
            logic [15:0] o;
            logic [63:0] s, r;
            logic [3:0]  ix;
            lat = $urandom_range(0, 3);
            sz  = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 2))
                                              : (($urandom_range(0, 1) == 1) ? 2'b11 : 2'b00);
            imm = ($urandom_range(0, 11) == 0) ? 8'($urandom) : codes[$urandom_range(0, 9)];
            b   = $urandom;
            o   = 16'($urandom);
            s   = {$urandom, $urandom};
            ix  = 4'(b + {{16{o[15]}}, o});
            r   = ($urandom_range(0, 1) == 1) ? mem[ix] : {$urandom, $urandom};
            run_op(sz, imm, b, o, s, r);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule